// File: doc/BRIEF.md
# Rotating-Top Floating-Point Operand Stack

This block holds the working operands of a floating-point unit. It has eight 80-bit entries. Software addresses them relative to a moving top pointer: ST(0) is the entry at the top, and ST(i) is the entry `i` places below it. The physical slot of ST(i) is `(top + i) mod 8`. A load pushes a new word onto the stack. A store reads ST(0) and then pops it. Each entry carries a valid tag, so pushing onto an occupied slot and consuming an empty slot are both caught. They are reported through two sticky flags and do not corrupt the stack.

The arithmetic is done outside the block. ST(0) and ST(1) are always driven on two operand ports. A third port reads ST(`rdIdx`) for any `rdIdx`. The external unit returns its answer on `resData`, and one of two opcodes commits it:
- The stack-form opcode writes the result into ST(1) and pops ST(0) in the same cycle, so the result becomes the new ST(0).
- The register-form opcode writes the result into ST(`opIdx`) and does not move the top.

The current top index and the eight tags are exported so that a status word can be built from them.

Top module: `tos_reg_file`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `topIdx` is 0, every bit of `tagVec` is 0 (empty), and both `ovfFlag` and `undFlag` are 0.
- R2: Opcode 1 (push) with the slot at `topIdx-1 mod 8` empty makes that slot valid with `pushData`. The top then becomes `topIdx-1 mod 8`, so `stData` shows the pushed word on the next cycle.
- R3: A push whose target slot is already valid sets `ovfFlag` and changes neither `topIdx`, `tagVec` nor any entry.
- R4: Opcode 2 (pop) with ST(0) valid clears the tag of that slot and moves `topIdx` to `topIdx+1 mod 8`.
- R5: These commands set `undFlag` and leave `topIdx`, `tagVec` and the entries unchanged:
  - a pop with ST(0) empty;
  - opcode 3 with ST(0) or ST(1) empty;
  - opcode 4 with ST(0) empty;
  - opcode 5 (peek) with ST(`opIdx`) empty.
- R6: Opcode 3 (stack-form commit) with ST(0) and ST(1) both valid writes `resData` into ST(1), clears the tag of ST(0) and adds one to `topIdx`. On the next cycle `stData` equals that `resData`.
- R7: Opcode 4 (register-form commit) with ST(0) valid writes `resData` into ST(`opIdx`) and marks it valid, leaving `topIdx` unchanged.
- R8: These outputs reflect the stored words and tags at all times, combinationally:
  - `rdData` and `rdValid` reflect physical slot `(topIdx + rdIdx) mod 8`;
  - `stData` reflects ST(0);
  - `st1Data` reflects ST(1).
- R9: `ovfFlag` and `undFlag` stay set once set, until opcode 6 clears both on the next edge.
- R10: Opcodes 0 and 7 change nothing. During a cycle in which any command commits, the read outputs still show the state from before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| opCode | input | 3 | Command: 0 idle, 1 push, 2 pop, 3 stack commit, 4 register commit, 5 peek, 6 clear flags, 7 idle |
| opIdx | input | 3 | Stack-relative index i for register commit and peek |
| pushData | input | 80 | Word loaded by a push |
| resData | input | 80 | Result returned by the external arithmetic |
| rdIdx | input | 3 | Stack-relative index for the free read port |
| rdData | output | 80 | Word stored at ST(rdIdx) |
| rdValid | output | 1 | Tag of ST(rdIdx) |
| stData | output | 80 | Word at ST(0) |
| st1Data | output | 80 | Word at ST(1) |
| topIdx | output | 3 | Physical index of the current top |
| tagVec | output | 8 | Valid tag per physical slot |
| ovfFlag | output | 1 | Sticky push-onto-occupied flag |
| undFlag | output | 1 | Sticky consume-of-empty flag |

## Verification
The stack-form commit does several things in a single edge:
- reads ST(0) and ST(1);
- writes ST(1);
- clears the tag of ST(0);
- moves the top.

A second collision is a free-port read that lands in the same cycle as any committing command. The bench provokes both by issuing stack commits, pushes and pops back to back while `rdIdx` is randomised. It samples the read ports one nanosecond after the driving edge and compares them with the model's state from before the command. Only after the next rising edge does it compare the moved top, the tags and ST(0) with the model's updated state.

// File: rtl/tos_pkg.sv
package tos_pkg;

  localparam int unsigned TOS_DEPTH = 8;
  localparam int unsigned TOS_IDX_W = $clog2(TOS_DEPTH);
  localparam int unsigned TOS_DATA_W = 80;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_PUSH   = 3'd1,
    OP_POP    = 3'd2,
    OP_ARITH  = 3'd3,
    OP_REGWR  = 3'd4,
    OP_PEEK   = 3'd5,
    OP_CLRFLG = 3'd6,
    OP_RSVD   = 3'd7
  } tosOp_e;

  typedef logic [TOS_IDX_W-1:0] slotIdx_t;

  // Strobes from control to datapath, one command per cycle.
  typedef struct packed {
    logic     wrEn;
    logic     wrSelPush;
    slotIdx_t wrSlot;
    logic     clrEn;
    slotIdx_t clrSlot;
  } dpStrobe_t;

  // Stack-relative to physical mapping; the depth is a power of two, so the wrap is free.
  function automatic slotIdx_t physOf(input slotIdx_t top, input slotIdx_t rel);
    return slotIdx_t'(top + rel);
  endfunction

endpackage

// File: rtl/tos_ctrl.sv
module tos_ctrl
  import tos_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  tosOp_e               op,
  input  slotIdx_t             opIdx,
  input  logic [TOS_DEPTH-1:0] tags,
  output dpStrobe_t            strb,
  output slotIdx_t             topIdx,
  output logic                 ovfFlag,
  output logic                 undFlag
);

  slotIdx_t topQ, topNext;
  logic ovfQ, undQ;
  logic setOvf, setUnd, clrFlags;

  slotIdx_t st0Slot, st1Slot, stiSlot, pushSlot;

  always_comb begin
    st0Slot  = physOf(topQ, slotIdx_t'(0));
    st1Slot  = physOf(topQ, slotIdx_t'(1));
    stiSlot  = physOf(topQ, opIdx);
    pushSlot = slotIdx_t'(topQ - slotIdx_t'(1));
  end

  always_comb begin
    strb     = '0;
    topNext  = topQ;
    setOvf   = 1'b0;
    setUnd   = 1'b0;
    clrFlags = 1'b0;
    unique case (op)
      OP_PUSH: begin
        if (tags[pushSlot]) begin
          setOvf = 1'b1;
        end else begin
          strb.wrEn      = 1'b1;
          strb.wrSelPush = 1'b1;
          strb.wrSlot    = pushSlot;
          topNext        = pushSlot;
        end
      end
      OP_POP: begin
        if (!tags[st0Slot]) begin
          setUnd = 1'b1;
        end else begin
          strb.clrEn   = 1'b1;
          strb.clrSlot = st0Slot;
          topNext      = st1Slot;
        end
      end
      OP_ARITH: begin
        if (!tags[st0Slot] || !tags[st1Slot]) begin
          setUnd = 1'b1;
        end else begin
          strb.wrEn    = 1'b1;
          strb.wrSlot  = st1Slot;
          strb.clrEn   = 1'b1;
          strb.clrSlot = st0Slot;
          topNext      = st1Slot;
        end
      end
      OP_REGWR: begin
        if (!tags[st0Slot]) begin
          setUnd = 1'b1;
        end else begin
          strb.wrEn   = 1'b1;
          strb.wrSlot = stiSlot;
        end
      end
      OP_PEEK: begin
        if (!tags[stiSlot]) setUnd = 1'b1;
      end
      OP_CLRFLG: clrFlags = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topQ <= '0;
      ovfQ <= 1'b0;
      undQ <= 1'b0;
    end else begin
      topQ <= topNext;
      if (clrFlags) begin
        ovfQ <= 1'b0;
        undQ <= 1'b0;
      end else begin
        ovfQ <= ovfQ | setOvf;
        undQ <= undQ | setUnd;
      end
    end
  end

  assign topIdx  = topQ;
  assign ovfFlag = ovfQ;
  assign undFlag = undQ;

endmodule

// File: rtl/tos_dpath.sv
module tos_dpath
  import tos_pkg::*;
#(
  parameter int unsigned DATA_W = TOS_DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [DATA_W-1:0]    pushData,
  input  logic [DATA_W-1:0]    resData,
  input  slotIdx_t             topIdx,
  input  slotIdx_t             rdIdx,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    stData,
  output logic [DATA_W-1:0]    st1Data,
  output logic [TOS_DEPTH-1:0] tags
);

  logic [DATA_W-1:0] ent [TOS_DEPTH];
  logic [TOS_DEPTH-1:0] tagQ;
  logic [DATA_W-1:0] wrVal;

  assign wrVal = strb.wrSelPush ? pushData : resData;

  // One storage slice per physical slot.
  for (genvar g = 0; g < TOS_DEPTH; g++) begin : gSlot
    logic hitWr, hitClr;
    assign hitWr  = strb.wrEn  && (strb.wrSlot  == slotIdx_t'(g));
    assign hitClr = strb.clrEn && (strb.clrSlot == slotIdx_t'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ent[g]  <= '0;
        tagQ[g] <= 1'b0;
      end else if (hitWr) begin
        ent[g]  <= wrVal;
        tagQ[g] <= 1'b1;
      end else if (hitClr) begin
        tagQ[g] <= 1'b0;
      end
    end
  end

  slotIdx_t rdSlot, st0Slot, st1Slot;
  always_comb begin
    rdSlot  = physOf(topIdx, rdIdx);
    st0Slot = physOf(topIdx, slotIdx_t'(0));
    st1Slot = physOf(topIdx, slotIdx_t'(1));
  end

  assign rdData  = ent[rdSlot];
  assign rdValid = tagQ[rdSlot];
  assign stData  = ent[st0Slot];
  assign st1Data = ent[st1Slot];
  assign tags    = tagQ;

endmodule

// File: rtl/tos_reg_file.sv
module tos_reg_file
  import tos_pkg::*;
#(
  parameter int unsigned DATA_W = TOS_DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           opCode,
  input  logic [TOS_IDX_W-1:0] opIdx,
  input  logic [DATA_W-1:0]    pushData,
  input  logic [DATA_W-1:0]    resData,
  input  logic [TOS_IDX_W-1:0] rdIdx,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    stData,
  output logic [DATA_W-1:0]    st1Data,
  output logic [TOS_IDX_W-1:0] topIdx,
  output logic [TOS_DEPTH-1:0] tagVec,
  output logic                 ovfFlag,
  output logic                 undFlag
);

  dpStrobe_t strb;
  tosOp_e    op;

  assign op = tosOp_e'(opCode);

  tos_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .op      (op),
    .opIdx   (opIdx),
    .tags    (tagVec),
    .strb    (strb),
    .topIdx  (topIdx),
    .ovfFlag (ovfFlag),
    .undFlag (undFlag)
  );

  tos_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pushData (pushData),
    .resData  (resData),
    .topIdx   (topIdx),
    .rdIdx    (rdIdx),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .stData   (stData),
    .st1Data  (st1Data),
    .tags     (tagVec)
  );

endmodule

// File: rtl/tos_checker.sv
module tos_checker
  import tos_pkg::*;
#(
  parameter int unsigned DATA_W = TOS_DATA_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           opCode,
  input logic [TOS_IDX_W-1:0] opIdx,
  input logic [DATA_W-1:0]    pushData,
  input logic [DATA_W-1:0]    resData,
  input logic [DATA_W-1:0]    stData,
  input logic [TOS_IDX_W-1:0] topIdx,
  input logic [TOS_DEPTH-1:0] tagVec,
  input logic                 ovfFlag,
  input logic                 undFlag
);

  slotIdx_t belowTop, aboveTop;
  assign belowTop = slotIdx_t'(topIdx - slotIdx_t'(1));
  assign aboveTop = slotIdx_t'(topIdx + slotIdx_t'(1));

  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (topIdx == '0 && tagVec == '0 && !ovfFlag && !undFlag));

  a_r2_push_lands: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_PUSH && !tagVec[belowTop])
      |=> (topIdx == $past(belowTop) && tagVec[topIdx] && stData == $past(pushData)));

  a_r3_no_overflow_change: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_PUSH && tagVec[belowTop])
      |=> (ovfFlag && $stable(topIdx) && $stable(tagVec)));

  a_r4_pop_frees: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_POP && tagVec[topIdx])
      |=> (topIdx == $past(aboveTop) && !tagVec[$past(topIdx)]));

  a_r5_underflow_pop: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_POP && !tagVec[topIdx])
      |=> (undFlag && $stable(topIdx) && $stable(tagVec)));

  a_r6_arith_result_on_top: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_ARITH && tagVec[topIdx] && tagVec[aboveTop])
      |=> (topIdx == $past(aboveTop) && stData == $past(resData)
           && !tagVec[$past(topIdx)]));

  a_r7_regwr_keeps_top: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_REGWR && tagVec[topIdx])
      |=> ($stable(topIdx) && tagVec[slotIdx_t'(topIdx + $past(opIdx))]));

  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (undFlag && opCode != OP_CLRFLG) |=> undFlag);

  a_r9_flags_clear: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_CLRFLG) |=> (!ovfFlag && !undFlag));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_IDLE || opCode == OP_RSVD)
      |=> ($stable(topIdx) && $stable(tagVec) && $stable(stData)));

endmodule

bind tos_reg_file tos_checker #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .opCode   (opCode),
  .opIdx    (opIdx),
  .pushData (pushData),
  .resData  (resData),
  .stData   (stData),
  .topIdx   (topIdx),
  .tagVec   (tagVec),
  .ovfFlag  (ovfFlag),
  .undFlag  (undFlag)
);

// File: tb/tos_reg_file_tb.sv
`timescale 1ns/1ps
module tos_reg_file_tb_top;

  localparam int DW = 80;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    opCode = '0;
  logic [2:0]    opIdx = '0;
  logic [DW-1:0] pushData = '0;
  logic [DW-1:0] resData = '0;
  logic [2:0]    rdIdx = '0;
  logic [DW-1:0] rdData, stData, st1Data;
  logic          rdValid, ovfFlag, undFlag;
  logic [2:0]    topIdx;
  logic [7:0]    tagVec;

  always #2 clk = ~clk;

  tos_reg_file dut_i (
    .clk(clk), .rstN(rstN), .opCode(opCode), .opIdx(opIdx),
    .pushData(pushData), .resData(resData), .rdIdx(rdIdx),
    .rdData(rdData), .rdValid(rdValid), .stData(stData), .st1Data(st1Data),
    .topIdx(topIdx), .tagVec(tagVec), .ovfFlag(ovfFlag), .undFlag(undFlag)
  );

  // Reference model
  logic [DW-1:0] mEnt [8];
  logic [7:0]    mTag;
  logic [2:0]    mTop;
  logic          mOvf, mUnd;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd80();
    return {$urandom() & 32'hFFFF, $urandom(), $urandom()};
  endfunction

  function automatic logic [2:0] ph(input logic [2:0] rel);
    return 3'(mTop + rel);
  endfunction

  // Model a command; returns the requirement tag that the outcome exercises.
  function automatic string modelStep(input logic [2:0] op, input logic [2:0] idx,
                                      input logic [DW-1:0] pd, input logic [DW-1:0] rs);
    logic [2:0] b;
    b = 3'(mTop - 3'd1);
    case (op)
      3'd1: if (mTag[b]) begin mOvf = 1; return "R3"; end
            else begin mEnt[b] = pd; mTag[b] = 1; mTop = b; return "R2"; end
      3'd2: if (!mTag[ph(0)]) begin mUnd = 1; return "R5"; end
            else begin mTag[ph(0)] = 0; mTop = ph(1); return "R4"; end
      3'd3: if (!mTag[ph(0)] || !mTag[ph(1)]) begin mUnd = 1; return "R5"; end
            else begin mEnt[ph(1)] = rs; mTag[ph(1)] = 1; mTag[ph(0)] = 0;
                       mTop = ph(1); return "R6"; end
      3'd4: if (!mTag[ph(0)]) begin mUnd = 1; return "R5"; end
            else begin mEnt[ph(idx)] = rs; mTag[ph(idx)] = 1; return "R7"; end
      3'd5: if (!mTag[ph(idx)]) begin mUnd = 1; return "R5"; end
            else return "R8";
      3'd6: begin mOvf = 0; mUnd = 0; return "R9"; end
      default: return "R10";
    endcase
  endfunction

  task automatic step(input logic [2:0] op, input logic [2:0] idx,
                      input logic [DW-1:0] pd, input logic [DW-1:0] rs,
                      input logic [2:0] rd);
    string req;
    @(negedge clk);
    opCode = op; opIdx = idx; pushData = pd; resData = rs; rdIdx = rd;
    #1;
    // R8 and R10: read ports show the state from before the command
    chk("R8", "rdData", rdData, mEnt[ph(rd)]);
    chk("R8", "rdValid", DW'(rdValid), DW'(mTag[ph(rd)]));
    chk("R10", "st1Data pre-commit", st1Data, mEnt[ph(1)]);
    req = modelStep(op, idx, pd, rs);
    @(posedge clk);
    #1;
    chk(req, "topIdx", DW'(topIdx), DW'(mTop));
    chk(req, "tagVec", DW'(tagVec), DW'(mTag));
    chk(req, "stData", stData, mEnt[mTop]);
    chk((op == 3'd6) ? "R9" : req, "ovfFlag", DW'(ovfFlag), DW'(mOvf));
    chk((op == 3'd6) ? "R9" : req, "undFlag", DW'(undFlag), DW'(mUnd));
  endtask

  initial begin
    #(200000 * 4);
    $display("FAIL watchdog: actual running expected finished");
    nChecks++; nFails++;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 8; k++) mEnt[k] = '0;
    mTag = '0; mTop = '0; mOvf = 0; mUnd = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "topIdx", DW'(topIdx), '0);
    chk("R1", "tagVec", DW'(tagVec), '0);
    chk("R1", "flags", DW'({ovfFlag, undFlag}), '0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "topIdx after release", DW'(topIdx), '0);

    // Directed: underflow on an empty stack, then clear.
    step(3'd2, 0, rnd80(), rnd80(), 0);
    step(3'd5, 3, rnd80(), rnd80(), 3);
    step(3'd6, 0, rnd80(), rnd80(), 0);
    // Fill all eight, wrap the top, then overflow.
    for (int k = 0; k < 8; k++) step(3'd1, 0, rnd80(), rnd80(), 3'(k));
    step(3'd1, 0, rnd80(), rnd80(), 7);
    step(3'd0, 0, rnd80(), rnd80(), 1);
    step(3'd7, 0, rnd80(), rnd80(), 2);
    // Stack-form commits down to one entry, then one more underflows.
    for (int k = 0; k < 8; k++) step(3'd3, 0, rnd80(), rnd80(), 3'(k));
    step(3'd4, 5, rnd80(), rnd80(), 5);
    step(3'd5, 5, rnd80(), rnd80(), 5);
    step(3'd6, 0, rnd80(), rnd80(), 0);
    step(3'd2, 0, rnd80(), rnd80(), 0);
    step(3'd4, 2, rnd80(), rnd80(), 2);

    // Random mix, weighted towards pushes so that the stack sees both ends.
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] op;
      int w;
      w = int'($urandom_range(0, 15));
      if (w < 5) op = 3'd1;
      else if (w < 12) op = 3'($urandom_range(2, 5));
      else op = 3'($urandom_range(0, 7));
      step(op, 3'($urandom_range(0, 7)), rnd80(), rnd80(), 3'($urandom_range(0, 7)));
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule